// File: doc/BRIEF.md
# Per-Pin Byte-Register GPIO Controller

This block is a GPIO controller reached through a byte-wide register window of 48 offsets. Each of 36 pins owns one control byte that holds its output-enable, its observed level and its output data value. Eight read-only summary registers at the bottom of the window pack the observed levels of eight consecutive pins per byte, so software can poll many pins with one read.

The observed level of a pin has two sources. A register write with output-enable set copies the written data bit into it. Otherwise a write leaves it alone. External pin inputs pass through a two-flop synchronizer, and a change on an input overwrites the observed level. Pin 1 drives an interrupt that is asserted while its level is low. Pin 9 drives an interrupt that is asserted while its level is high. An input change on a pin that is configured as an output is recorded, and it also raises a one-cycle error flag.

Top module: `gbc_gpio_ctl`

## Requirements
- R1: Offset 8+n reads back pin n's control byte (n = 0..35). A write there stores bits 7:3, bit 2 (output enable) and bit 0 (output data) exactly as written.
- R2: Bit 1 (observed level) of a written byte is discarded. When the written bit 2 is 1, bit 1 becomes the written bit 0. When it is 0, bit 1 keeps its previous value.
- R3: Offsets 0..7 are read-only level summaries. Bit i of offset k is bit 1 of pin 8k+i, and pins above 35 read as 0. Writes to these offsets change nothing.
- R4: Offsets 44..47 read as zero, and writes to them change no register.
- R5: A change on pin_in[n] sets bit 1 of pin n to the new level. The change is visible on the third rising edge after the input is applied, and only bit 1 is altered.
- R6: irq_on_low is 1 exactly while pin 1's observed level is 0, whether that level came from an input or from a write.
- R7: irq_on_high is 1 exactly while pin 9's observed level is 1.
- R8: After reset, every control byte is 0x00 except pin 1's, which is 0x02. Both interrupts and err_pulse are 0.
- R9: An input change on a pin whose stored output enable is 1 raises err_pulse for one cycle, in the same cycle the level is recorded.
- R10: When a write and an input change hit the same pin in the same cycle, bit 1 takes the input level and the other bits come from the write. err_pulse is judged on the output enable held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset for read and write |
| bus_we | input | 1 | Write strobe for the byte at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data at bus_addr |
| pin_in | input | 36 | Asynchronous external pin levels |
| irq_on_low | output | 1 | Interrupt, asserted while pin 1's level is 0 |
| irq_on_high | output | 1 | Interrupt, asserted while pin 9's level is 1 |
| err_pulse | output | 1 | One-cycle flag for input activity on an output pin |

## Verification
A register write and a synchronized input change can land on the same control byte on the same clock edge. The bench provokes this by applying the input two falling edges before it issues the write, so both take effect on the third rising edge. It then reads the byte back, expecting bit 1 from the pin and all other bits from the write. It also samples err_pulse on that same edge, once with the pin previously an input and once with the pin previously an output, to confirm that the error flag follows the output enable held before the write.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [4:0] spare;
        logic       oe;
        logic       lvl;
        logic       dout;
    } ctl_byte_t;

    // Store the written byte, dropping its level bit; take the level from
    // the data bit when output is enabled, else keep the old level.
    function automatic ctl_byte_t merge_write(ctl_byte_t old, logic [BYTE_W-1:0] wd);
        ctl_byte_t r;
        r     = ctl_byte_t'(wd);
        r.lvl = wd[2] ? wd[0] : old.lvl;
        return r;
    endfunction
endpackage

// File: rtl/gbc_in_sync.sv
module gbc_in_sync #(
    parameter int             N       = 36,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] lvl_now,
    output logic [N-1:0] chg
);
    logic [N-1:0] stg [STAGES];
    logic [N-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
            seen <= RST_VAL;
        end else begin
            stg[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            seen <= stg[STAGES-1];
        end
    end

    assign lvl_now = stg[STAGES-1];
    assign chg     = stg[STAGES-1] ^ seen;
endmodule

// File: rtl/gbc_ctl_bank.sv
module gbc_ctl_bank
    import gbc_pkg::*;
#(
    parameter int N        = 36,
    parameter int BASE     = 8,
    parameter int AW       = 6,
    parameter int HIGH_PIN = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [N-1:0]             ev_chg,
    input  logic [N-1:0]             ev_lvl,
    output ctl_byte_t [N-1:0]        ctl_q,
    output logic                     err_q
);
    logic [N-1:0] hit;
    logic [N-1:0] oe_vec;

    for (genvar i = 0; i < N; i++) begin : g_pin
        localparam ctl_byte_t RST_BYTE = (i == HIGH_PIN) ? ctl_byte_t'(8'h02) : ctl_byte_t'(8'h00);
        ctl_byte_t nxt;

        assign hit[i]    = wr_en && (wr_addr == AW'(BASE + i));
        assign oe_vec[i] = ctl_q[i].oe;

        always_comb begin
            nxt = ctl_q[i];
            if (hit[i])    nxt = merge_write(ctl_q[i], wr_data);
            if (ev_chg[i]) nxt.lvl = ev_lvl[i];
        end

        always_ff @(posedge clk) begin
            if (rst)                      ctl_q[i] <= RST_BYTE;
            else if (hit[i] || ev_chg[i]) ctl_q[i] <= nxt;
        end

        // R2: output-enabled write copies data into level
        a_r2_oe_copies_data: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && wr_data[2] && !ev_chg[i]) |=> (ctl_q[i].lvl == $past(wr_data[0])));
        // R2: write without output enable keeps level
        a_r2_keep_level: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && !wr_data[2] && !ev_chg[i]) |=> $stable(ctl_q[i].lvl));
        // R5: nothing touches the byte when there is neither write nor input change
        a_r5_quiet_stable: assert property (@(posedge clk) disable iff (rst)
            (!hit[i] && !ev_chg[i]) |=> $stable(ctl_q[i]));
        // R10: input change wins for the level bit
        a_r10_input_wins: assert property (@(posedge clk) disable iff (rst)
            ev_chg[i] |=> (ctl_q[i].lvl == $past(ev_lvl[i])));
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= |(ev_chg & oe_vec);
    end
endmodule

// File: rtl/gbc_rd_mux.sv
module gbc_rd_mux
    import gbc_pkg::*;
#(
    parameter int N        = 36,
    parameter int LVL_REGS = 8,
    parameter int AW       = 6
) (
    input  logic [AW-1:0]       addr,
    input  ctl_byte_t [N-1:0]   ctl_q,
    output logic [BYTE_W-1:0]   rdata
);
    localparam int LVL_BITS = LVL_REGS * BYTE_W;
    logic [LVL_BITS-1:0] lvl_vec;

    for (genvar j = 0; j < LVL_BITS; j++) begin : g_lvl
        if (j < N) begin : g_live
            assign lvl_vec[j] = ctl_q[j].lvl;
        end else begin : g_zero
            assign lvl_vec[j] = 1'b0;
        end
    end

    always_comb begin
        int a;
        a     = int'(addr);
        rdata = '0;
        if (a < LVL_REGS)
            rdata = lvl_vec[a*BYTE_W +: BYTE_W];
        else if (a - LVL_REGS < N)
            rdata = ctl_q[a - LVL_REGS];
    end
endmodule

// File: rtl/gbc_gpio_ctl.sv
module gbc_gpio_ctl
    import gbc_pkg::*;
#(
    parameter int NUM_PINS    = 36,
    parameter int LVL_REGS    = 8,
    parameter int WINDOW      = 48,
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_LO_PIN  = 1,
    parameter int IRQ_HI_PIN  = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [5:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic                 irq_on_low,
    output logic                 irq_on_high,
    output logic                 err_pulse
);
    localparam int AW = $clog2(WINDOW);
    localparam logic [NUM_PINS-1:0] PIN_RST = NUM_PINS'(1) << IRQ_LO_PIN;
    localparam int CTL_END = LVL_REGS + NUM_PINS;

    logic [NUM_PINS-1:0]    lvl_now, chg;
    ctl_byte_t [NUM_PINS-1:0] ctl_q;

    gbc_in_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .lvl_now(lvl_now), .chg(chg)
    );

    gbc_ctl_bank #(.N(NUM_PINS), .BASE(LVL_REGS), .AW(AW), .HIGH_PIN(IRQ_LO_PIN)) u_bank (
        .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(AW'(bus_addr)), .wr_data(bus_wdata),
        .ev_chg(chg), .ev_lvl(lvl_now), .ctl_q(ctl_q), .err_q(err_pulse)
    );

    gbc_rd_mux #(.N(NUM_PINS), .LVL_REGS(LVL_REGS), .AW(AW)) u_rd (
        .addr(AW'(bus_addr)), .ctl_q(ctl_q), .rdata(bus_rdata)
    );

    assign irq_on_low  = !ctl_q[IRQ_LO_PIN].lvl;
    assign irq_on_high =  ctl_q[IRQ_HI_PIN].lvl;

    // R4: unmapped tail of the window reads zero
    a_r4_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) >= CTL_END) |-> (bus_rdata == 8'h00));
    // R9: error flag follows an input change
    a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(|chg));
endmodule

// File: tb/gbc_gpio_ctl_tb.sv
module gbc_gpio_ctl_tb;
    typedef struct {
        int         kind;   // 0 rdata, 1 irq_on_low, 2 irq_on_high, 3 err_pulse
        logic [7:0] exp;
        string      tag;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [35:0] pin_in = 36'h2;
    logic        irq_on_low, irq_on_high, err_pulse;

    int   n_run = 0, n_fail = 0;
    bit   done = 0;
    exp_t sb [$];

    always #5 clk = ~clk;

    gbc_gpio_ctl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .irq_on_low(irq_on_low), .irq_on_high(irq_on_high), .err_pulse(err_pulse)
    );

    // monitor: compare every queued item just after the rising edge
    initial forever begin
        @(posedge clk);
        #2;
        while (sb.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e = sb.pop_front();
            case (e.kind)
                0:       act = bus_rdata;
                1:       act = {7'd0, irq_on_low};
                2:       act = {7'd0, irq_on_high};
                default: act = {7'd0, err_pulse};
            endcase
            n_run++;
            if (act !== e.exp) begin
                n_fail++;
                $display("FAIL %s actual=%02h expected=%02h", e.tag, act, e.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(int kind, logic [7:0] exp, string tag);
        exp_t e;
        e.kind = kind; e.exp = exp; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
        bus_addr = a;
        push(0, exp, tag);
        tick();
    endtask

    task automatic sig(int kind, logic exp, string tag);
        push(kind, {7'd0, exp}, tag);
        tick();
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 0;
    endtask

    task automatic settle();
        repeat (3) tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 0;
        tick();
        // R8 reset state
        rd(6'd9, 8'h02, "R8 pin1 byte");
        rd(6'd8, 8'h00, "R8 pin0 byte");
        rd(6'd0, 8'h02, "R3 R8 level reg 0");
        sig(1, 1'b0, "R8 R6 irq_on_low idle");
        sig(2, 1'b0, "R8 R7 irq_on_high idle");
        sig(3, 1'b0, "R8 err idle");
        // R1 R2 writes on pin 5
        wr(6'd13, 8'h05); rd(6'd13, 8'h07, "R2 oe copies data 1");
        wr(6'd13, 8'h06); rd(6'd13, 8'h04, "R2 bit1 discarded, data 0");
        wr(6'd13, 8'hF3); rd(6'd13, 8'hF1, "R1 upper bits stored, R2 level kept");
        // R5 input on pin 5 (not an output now)
        pin_in[5] = 1'b1;
        tick(); tick();
        sig(3, 1'b0, "R9 no err on input pin");
        rd(6'd13, 8'hF3, "R5 input recorded in bit1 only");
        wr(6'd13, 8'h08); rd(6'd13, 8'h0A, "R2 level kept without oe");
        // R3 level registers
        wr(6'd0, 8'hFF); rd(6'd0, 8'h22, "R3 level reg read-only and packed");
        // R4 hole
        wr(6'd44, 8'hFF);
        rd(6'd44, 8'h00, "R4 offset 44 reads zero");
        rd(6'd47, 8'h00, "R4 offset 47 reads zero");
        rd(6'd43, 8'h00, "R4 write to hole left pin35 alone");
        pin_in[35] = 1'b1; settle();
        rd(6'd4, 8'h08, "R3 level reg 4 pin35");
        rd(6'd5, 8'h00, "R3 level reg 5 beyond pins");
        // R6 pin1 interrupt
        pin_in[1] = 1'b0; settle();
        sig(1, 1'b1, "R6 irq asserted on low");
        rd(6'd9, 8'h00, "R5 pin1 level low");
        pin_in[1] = 1'b1; settle();
        sig(1, 1'b0, "R6 irq released on high");
        // R7 pin9 interrupt
        pin_in[9] = 1'b1; settle();
        sig(2, 1'b1, "R7 irq asserted on high");
        pin_in[9] = 1'b0; settle();
        sig(2, 1'b0, "R7 irq released on low");
        // R9 error on output pin 3
        wr(6'd11, 8'h04);
        pin_in[3] = 1'b1;
        tick(); tick();
        sig(3, 1'b1, "R9 err raised");
        sig(3, 1'b0, "R9 err one cycle");
        rd(6'd11, 8'h06, "R9 level still recorded");
        // R10 same-cycle collisions
        pin_in[12] = 1'b1;
        tick(); tick();
        wr(6'd20, 8'h00);
        rd(6'd20, 8'h02, "R10 input level kept over write");
        pin_in[13] = 1'b1;
        tick(); tick();
        push(3, 8'h00, "R10 no err, old oe was 0");
        wr(6'd21, 8'h04);
        rd(6'd21, 8'h06, "R10 write oe with input level");
        pin_in[3] = 1'b0;
        tick(); tick();
        push(3, 8'h01, "R10 err from old oe");
        wr(6'd11, 8'h00);
        rd(6'd11, 8'h00, "R10 pin3 byte after collision");
        // R6 level from a write
        wr(6'd9, 8'h04); sig(1, 1'b1, "R6 irq from written low level");
        wr(6'd9, 8'h05); sig(1, 1'b0, "R6 irq cleared by written high");
        tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule